// File: doc/BRIEF.md
# Dual-Clock Queue with Selectable Look-Ahead Output

This block is a first-in first-out queue that joins two unrelated clock domains: words are written on `wclk` and read on `rclk`. Pointers cross between the domains in Gray code through two-flop synchronizers. Because of this, each side sees the other side's progress a few cycles late. The flags can therefore be late in reporting data or space, but they never report data or space that is not there.

The output timing mode is sampled while `rst_n` is low and holds until the next reset. In standard mode, every word, including the first, is fetched by an explicit read request. In this mode `out_rdy` means "the queue holds data". In look-ahead mode, the oldest word moves to `rd_data` without any request and `out_rdy` means "`rd_data` holds a valid word"; a read request then consumes that word. In both modes `in_rdy` means "the queue has space". Both modes provide an almost-empty flag `ae_n` and an almost-full flag `af_n`. Their offsets are sampled from input ports during reset.

The read side is driven by a three-state machine. Reset loads `RS_STD` when `fwft_sel` is low and `RS_FT_DRY` when it is high. `RS_STD` has only a self-loop: each request that finds data loads the word and advances the pointer. `RS_FT_DRY` moves to `RS_FT_WET` on *fill*, which happens when stored data becomes visible and the head word is loaded. `RS_FT_WET` loops on *pop-refill*, where a request is made while a second word is stored and the next word is loaded. It returns to `RS_FT_DRY` on *pop-drain*, where a request consumes the last stored word.

Top module: `fifo_dual_clk`

## Requirements
- R1: The mode is sampled from `fwft_sel` on every `rclk` edge while `rst_n` is low: 0 selects standard mode and 1 selects look-ahead mode. Changes to `fwft_sel` after reset have no effect.
- R2: A word is written at a `wclk` rising edge only when `wr_en_n` and `wr_sel_n` are both 0 and the queue is not full. If either input is 1, nothing is stored.
- R3: In standard mode, a read request (`rd_en_n` = 0 and `rd_sel_n` = 0 at an `rclk` edge) that finds data loads the oldest word onto `rd_data` at that edge. A request made while the queue is empty leaves `rd_data` and the queue unchanged.
- R4: In look-ahead mode, the first word written into an empty queue appears on `rd_data`, with `out_rdy` = 1, within four `rclk` rising edges after the write edge and without any read request. A request while `out_rdy` = 1 consumes that word. `out_rdy` falls at the edge that consumes the last word.
- R5: Words leave in the order they were written, in both modes and at any clock ratio.
- R6: In standard mode, `out_rdy` rises after the first write, once the write is synchronized and has passed two further `rclk` register stages. It falls at the `rclk` edge that reads the last word.
- R7: `in_rdy` falls at the write edge that stores the D-th word (D = 2^AW). While it is low, writes are ignored. It rises again after a read.
- R8: `ae_n` is 0 while n or fewer words are stored and 1 once n+1 or more are stored, counted on the read side. In look-ahead mode, the word shown on `rd_data` counts as stored.
- R9: `af_n` falls at the write edge that brings the stored count to D−m, and stays 1 below that count.
- R10: n and m are sampled from `empty_off` and `full_off` while `rst_n` is low. A value of 0 selects the defaults DEF_EMPTY_OFF and DEF_FULL_OFF (both 2). Port changes after reset have no effect.
- R11: `rd_oe` is 1 exactly when `rd_sel_n` was 0 at the previous `rclk` rising edge, and is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Master reset, active low, sampled by both clocks |
| fwft_sel | input | 1 | Mode select sampled during reset: 1 = look-ahead |
| empty_off | input | AW | Almost-empty offset n, 0 = default |
| full_off | input | AW | Almost-full offset m, 0 = default |
| wr_data | input | DW | Write data |
| wr_en_n | input | 1 | Write enable, active low |
| wr_sel_n | input | 1 | Write select, active low |
| in_rdy | output | 1 | Space available |
| af_n | output | 1 | Almost full, active low |
| rd_en_n | input | 1 | Read enable, active low |
| rd_sel_n | input | 1 | Read select, active low |
| rd_data | output | DW | Read data |
| rd_oe | output | 1 | Read data drive enable (models high impedance) |
| out_rdy | output | 1 | Standard: data stored; look-ahead: `rd_data` valid |
| ae_n | output | 1 | Almost empty, active low |

## Verification
A corrupted pointer or a lost Gray bit shows up at the first read that returns a word out of order or a repeated word. It also shows up as `in_rdy` or `ae_n` switching at a count other than D, n or n+1, and this is visible in the same cycle in which the count crosses. A wrong read-side state is visible within four `rclk` edges of a write: in look-ahead mode no word appears, or in standard mode a word appears unrequested. A mode or offset that is not held after reset is exposed by the first fill that follows, because the bench deliberately changes those ports once reset has been released.

// File: rtl/fifo_pkg.sv
package fifo_pkg;
    typedef enum logic [1:0] {
        RS_STD    = 2'd0,
        RS_FT_DRY = 2'd1,
        RS_FT_WET = 2'd2
    } rd_state_e;
endpackage

// File: rtl/fifo_sync.sv
module fifo_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/fifo_ram.sv
module fifo_ram #(
    parameter int DW = 10,
    parameter int AW = 4
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/fifo_wr_side.sv
module fifo_wr_side #(
    parameter int AW           = 4,
    parameter int DEF_FULL_OFF = 2
) (
    input  logic          wclk,
    input  logic          rst_n,
    input  logic          wr_en_n,
    input  logic          wr_sel_n,
    input  logic [AW-1:0] full_off,
    input  logic [AW:0]   rgray_sync,
    output logic [AW:0]   wgray,
    output logic [AW-1:0] waddr,
    output logic          we,
    output logic          in_rdy,
    output logic          af_n
);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] DEPTH_P = PW'(1 << AW);

    logic [PW-1:0] wptr, rbin, count_w;
    logic [AW-1:0] m_q;
    logic          space, sp1, sp2;

    always_comb begin
        rbin[PW-1] = rgray_sync[PW-1];
        for (int i = PW - 2; i >= 0; i--) rbin[i] = rbin[i+1] ^ rgray_sync[i];
    end

    assign count_w = wptr - rbin;
    assign space   = (count_w != DEPTH_P);
    assign we      = !wr_en_n && !wr_sel_n && space;
    assign waddr   = wptr[AW-1:0];

    always_ff @(posedge wclk) begin
        if (!rst_n) begin
            wptr  <= '0;
            wgray <= '0;
            sp1   <= 1'b1;
            sp2   <= 1'b1;
            m_q   <= (full_off == '0) ? AW'(DEF_FULL_OFF) : full_off;
        end else begin
            wptr  <= wptr + PW'(we);
            wgray <= (wptr + PW'(we)) ^ ((wptr + PW'(we)) >> 1);
            sp1   <= space;
            sp2   <= sp1;
        end
    end

    assign in_rdy = sp2 && space;
    assign af_n   = (count_w < (DEPTH_P - {1'b0, m_q}));

    AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (!rst_n)
        count_w <= DEPTH_P);                                          // R7
    AST_FULL_BLOCKS: assert property (@(posedge wclk) disable iff (!rst_n)
        !space |=> (wptr == $past(wptr)));                            // R7
    AST_WRITE_GATED: assert property (@(posedge wclk) disable iff (!rst_n)
        (wr_en_n || wr_sel_n) |=> (wptr == $past(wptr)));             // R2
endmodule

// File: rtl/fifo_rd_side.sv
module fifo_rd_side
    import fifo_pkg::*;
#(
    parameter int DW            = 10,
    parameter int AW            = 4,
    parameter int DEF_EMPTY_OFF = 2
) (
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          fwft_sel,
    input  logic          rd_en_n,
    input  logic          rd_sel_n,
    input  logic [AW-1:0] empty_off,
    input  logic [AW:0]   wgray_sync,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_raddr,
    output logic [AW:0]   rgray,
    output logic [DW-1:0] rd_data,
    output logic          rd_oe,
    output logic          out_rdy,
    output logic          ae_n
);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] DEPTH_P = PW'(1 << AW);

    rd_state_e     st_q, st_d;
    logic [PW-1:0] rptr, wbin, count_r;
    logic [AW-1:0] n_q;
    logic          avail, two_plus, pop, adv, load, look, av1, av2;

    always_comb begin
        wbin[PW-1] = wgray_sync[PW-1];
        for (int i = PW - 2; i >= 0; i--) wbin[i] = wbin[i+1] ^ wgray_sync[i];
    end

    assign count_r  = wbin - rptr;
    assign avail    = (count_r != '0);
    assign two_plus = (count_r > PW'(1));
    assign pop      = !rd_en_n && !rd_sel_n;

    // next state and per-cycle controls
    always_comb begin
        st_d = st_q;
        adv  = 1'b0;
        load = 1'b0;
        look = 1'b0;
        unique case (st_q)
            RS_STD: begin
                if (pop && avail) begin
                    adv  = 1'b1;
                    load = 1'b1;
                end
            end
            RS_FT_DRY: begin
                if (avail) begin
                    load = 1'b1;
                    st_d = RS_FT_WET;
                end
            end
            RS_FT_WET: begin
                if (pop) begin
                    adv = 1'b1;
                    if (two_plus) begin
                        load = 1'b1;
                        look = 1'b1;
                    end else begin
                        st_d = RS_FT_DRY;
                    end
                end
            end
            default: st_d = RS_STD;
        endcase
    end

    assign mem_raddr = rptr[AW-1:0] + AW'(look);

    // state register, mode sampled during reset
    always_ff @(posedge rclk) begin
        if (!rst_n) st_q <= fwft_sel ? RS_FT_DRY : RS_STD;
        else        st_q <= st_d;
    end

    // datapath and output registers
    always_ff @(posedge rclk) begin
        if (!rst_n) begin
            rptr    <= '0;
            rgray   <= '0;
            rd_data <= '0;
            rd_oe   <= 1'b0;
            av1     <= 1'b0;
            av2     <= 1'b0;
            n_q     <= (empty_off == '0) ? AW'(DEF_EMPTY_OFF) : empty_off;
        end else begin
            rptr  <= rptr + PW'(adv);
            rgray <= (rptr + PW'(adv)) ^ ((rptr + PW'(adv)) >> 1);
            if (load) rd_data <= mem_rdata;
            rd_oe <= !rd_sel_n;
            av1   <= avail;
            av2   <= av1;
        end
    end

    assign out_rdy = (st_q == RS_STD) ? (av2 && avail) : (st_q == RS_FT_WET);
    assign ae_n    = (count_r > {1'b0, n_q});

    AST_NO_UNDERFLOW: assert property (@(posedge rclk) disable iff (!rst_n)
        count_r <= DEPTH_P);                                          // R5
    AST_EMPTY_READ_IGNORED: assert property (@(posedge rclk) disable iff (!rst_n)
        (st_q == RS_STD && !avail) |=> (rptr == $past(rptr)));        // R3
    AST_SHOWN_WORD_STORED: assert property (@(posedge rclk) disable iff (!rst_n)
        (st_q == RS_FT_WET) |-> avail);                               // R4
    AST_MODE_KEPT: assert property (@(posedge rclk) disable iff (!rst_n)
        (st_q == RS_STD) |=> (st_q == RS_STD));                       // R1
    AST_READY_HAS_DATA: assert property (@(posedge rclk) disable iff (!rst_n)
        out_rdy |-> avail);                                           // R6
endmodule

// File: rtl/fifo_dual_clk.sv
module fifo_dual_clk #(
    parameter int DW            = 10,
    parameter int AW            = 4,
    parameter int DEF_EMPTY_OFF = 2,
    parameter int DEF_FULL_OFF  = 2
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          fwft_sel,
    input  logic [AW-1:0] empty_off,
    input  logic [AW-1:0] full_off,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_en_n,
    input  logic          wr_sel_n,
    output logic          in_rdy,
    output logic          af_n,
    input  logic          rd_en_n,
    input  logic          rd_sel_n,
    output logic [DW-1:0] rd_data,
    output logic          rd_oe,
    output logic          out_rdy,
    output logic          ae_n
);
    localparam int PW = AW + 1;

    logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
    logic [AW-1:0] waddr, raddr;
    logic [DW-1:0] mem_q;
    logic          we;

    fifo_ram #(.DW(DW), .AW(AW)) u_ram (
        .wclk(wclk), .we(we), .waddr(waddr), .wdata(wr_data),
        .raddr(raddr), .rdata(mem_q)
    );

    fifo_sync #(.W(PW), .STAGES(2)) u_w2r (
        .clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_s)
    );

    fifo_sync #(.W(PW), .STAGES(2)) u_r2w (
        .clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_s)
    );

    fifo_wr_side #(.AW(AW), .DEF_FULL_OFF(DEF_FULL_OFF)) u_wr (
        .wclk(wclk), .rst_n(rst_n), .wr_en_n(wr_en_n), .wr_sel_n(wr_sel_n),
        .full_off(full_off), .rgray_sync(rgray_s), .wgray(wgray),
        .waddr(waddr), .we(we), .in_rdy(in_rdy), .af_n(af_n)
    );

    fifo_rd_side #(.DW(DW), .AW(AW), .DEF_EMPTY_OFF(DEF_EMPTY_OFF)) u_rd (
        .rclk(rclk), .rst_n(rst_n), .fwft_sel(fwft_sel),
        .rd_en_n(rd_en_n), .rd_sel_n(rd_sel_n), .empty_off(empty_off),
        .wgray_sync(wgray_s), .mem_rdata(mem_q), .mem_raddr(raddr),
        .rgray(rgray), .rd_data(rd_data), .rd_oe(rd_oe),
        .out_rdy(out_rdy), .ae_n(ae_n)
    );
endmodule

// File: tb/sim_fifo_dual_clk.sv
module sim_fifo_dual_clk;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 10;
    localparam int AW = 4;
    localparam int D  = 1 << AW;

    logic          wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0, fwft_sel = 1'b0;
    logic [AW-1:0] empty_off = '0, full_off = '0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_en_n = 1'b1, wr_sel_n = 1'b1, rd_en_n = 1'b1, rd_sel_n = 1'b1;
    logic          in_rdy, af_n, rd_oe, out_rdy, ae_n;
    logic [DW-1:0] rd_data;
    int            rhalf = 7;
    int            total = 0, bad = 0;
    bit            done = 1'b0;

    always #(CLK_PERIOD / 2) wclk = ~wclk;
    always begin
        #(rhalf);
        rclk = ~rclk;
    end

    fifo_dual_clk #(.DW(DW), .AW(AW)) u0 (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .fwft_sel(fwft_sel),
        .empty_off(empty_off), .full_off(full_off), .wr_data(wr_data),
        .wr_en_n(wr_en_n), .wr_sel_n(wr_sel_n), .in_rdy(in_rdy), .af_n(af_n),
        .rd_en_n(rd_en_n), .rd_sel_n(rd_sel_n), .rd_data(rd_data),
        .rd_oe(rd_oe), .out_rdy(out_rdy), .ae_n(ae_n)
    );

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(bit ft, int eo, int fo);
        rst_n = 1'b0; fwft_sel = ft;
        empty_off = AW'(eo); full_off = AW'(fo);
        rd_en_n = 1'b1; wr_en_n = 1'b1; wr_sel_n = 1'b1;
        repeat (4) @(posedge rclk);
        repeat (4) @(posedge wclk);
        @(negedge wclk);
        rst_n = 1'b1;
        repeat (2) @(posedge rclk);
        fwft_sel = !ft; empty_off = AW'(7); full_off = AW'(9);   // ignored after reset
    endtask

    task automatic settle();
        repeat (8) @(posedge rclk);
        repeat (8) @(posedge wclk);
        @(negedge rclk);
    endtask

    task automatic wr(int data, bit en_n, bit sel_n);
        @(negedge wclk);
        wr_data = DW'(data); wr_en_n = en_n; wr_sel_n = sel_n;
        @(posedge wclk);
        #1;
        wr_en_n = 1'b1; wr_sel_n = 1'b1;
    endtask

    task automatic std_read(output int data);
        @(negedge rclk);
        rd_en_n = 1'b0;
        @(posedge rclk);
        @(negedge rclk);
        data = int'(rd_data);
        rd_en_n = 1'b1;
    endtask

    task automatic ft_pop(string req, int exp);
        @(negedge rclk);
        check({req, " shown word"}, int'(rd_data), exp);
        check({req, " ready before pop"}, int'(out_rdy), 1);
        rd_en_n = 1'b0;
        @(posedge rclk);
        #1;
        rd_en_n = 1'b1;
    endtask

    // reset state, output enable, defaults
    task automatic t_reset_state();
        do_reset(1'b0, 0, 0);
        settle();
        check("R1 standard after reset, out_rdy", int'(out_rdy), 0);
        check("R7 in_rdy after reset", int'(in_rdy), 1);
        check("R8 ae_n after reset", int'(ae_n), 0);
        check("R9 af_n after reset", int'(af_n), 1);
        check("R11 rd_oe with select high", int'(rd_oe), 0);
        @(negedge rclk); rd_sel_n = 1'b0;
        @(negedge rclk);
        check("R11 rd_oe after select low", int'(rd_oe), 1);
    endtask

    // standard mode: gating, explicit reads, flags
    task automatic t_standard();
        int v;
        std_read(v);
        check("R3 empty read leaves rd_data", v, 0);
        check("R3 empty read out_rdy", int'(out_rdy), 0);
        wr(10'h2AA, 1'b0, 1'b1);
        wr(10'h155, 1'b1, 1'b0);
        settle();
        check("R2 gated writes store nothing", int'(out_rdy), 0);
        wr(1, 1'b0, 1'b0);
        settle();
        check("R6 out_rdy after first write", int'(out_rdy), 1);
        check("R1 no word shown in standard mode", int'(rd_data), 0);
        check("R8 ae_n with 1 stored (n=2)", int'(ae_n), 0);
        wr(2, 1'b0, 1'b0);
        wr(3, 1'b0, 1'b0);
        settle();
        check("R8 ae_n with 3 stored", int'(ae_n), 1);
        std_read(v);
        check("R3 first read", v, 1);
        check("R8 ae_n back to 2 stored", int'(ae_n), 0);
        std_read(v);
        check("R5 second read", v, 2);
        std_read(v);
        check("R5 third read", v, 3);
        check("R6 out_rdy falls on last read", int'(out_rdy), 0);
    endtask

    // fill to full, ignored write, drain
    task automatic t_fill();
        int v;
        for (int i = 0; i < D; i++) begin
            wr(100 + i, 1'b0, 1'b0);
            @(negedge wclk);
            if (i == D - 4) check("R9 af_n at D-m-1 stored", int'(af_n), 1);
            if (i == D - 3) check("R9 af_n at D-m stored", int'(af_n), 0);
        end
        check("R7 in_rdy low when full", int'(in_rdy), 0);
        wr(999, 1'b0, 1'b0);
        settle();
        check("R7 in_rdy stays low", int'(in_rdy), 0);
        std_read(v);
        check("R5 head after full", v, 100);
        settle();
        check("R7 in_rdy back after read", int'(in_rdy), 1);
        for (int i = 1; i < D; i++) begin
            std_read(v);
            check("R5 drain order", v, 100 + i);
        end
        check("R7 write while full was not stored", int'(out_rdy), 0);
    endtask

    // look-ahead mode
    task automatic t_lookahead();
        int edges = 0;
        do_reset(1'b1, 3, 5);
        rd_sel_n = 1'b0;
        settle();
        check("R4 out_rdy empty", int'(out_rdy), 0);
        wr(200, 1'b0, 1'b0);
        for (int k = 1; k <= 8; k++) begin
            @(posedge rclk);
            @(negedge rclk);
            edges = k;
            if (out_rdy) break;
        end
        check("R4 first word within four rclk edges", int'(edges <= 4), 1);
        check("R4 first word shown without request", int'(rd_data), 200);
        check("R1 look-ahead kept after fwft_sel change", int'(out_rdy), 1);
        check("R8 ae_n one stored (n=3)", int'(ae_n), 0);
        for (int i = 1; i < 5; i++) wr(200 + i, 1'b0, 1'b0);
        settle();
        check("R8 ae_n five stored", int'(ae_n), 1);
        check("R4 word held without request", int'(rd_data), 200);
        ft_pop("R4", 200);
        ft_pop("R5", 201);
        @(negedge rclk);
        check("R8 ae_n three stored incl shown", int'(ae_n), 0);
        ft_pop("R5", 202);
        ft_pop("R5", 203);
        ft_pop("R5", 204);
        @(negedge rclk);
        check("R4 out_rdy falls after last pop", int'(out_rdy), 0);
        for (int i = 0; i < D - 5; i++) begin
            wr(300 + i, 1'b0, 1'b0);
            @(negedge wclk);
            if (i == D - 7) check("R10 af_n at D-m-1 (m=5)", int'(af_n), 1);
            if (i == D - 6) check("R10 af_n at D-m (m=5)", int'(af_n), 0);
        end
        settle();
        for (int i = 0; i < D - 5; i++) ft_pop("R5 look-ahead drain", 300 + i);
    endtask

    // slow read side burst
    task automatic t_slow_read();
        int v;
        rhalf = 11;
        do_reset(1'b0, 0, 0);
        rd_sel_n = 1'b0;
        for (int i = 0; i < 8; i++) wr(500 + i, 1'b0, 1'b0);
        settle();
        for (int i = 0; i < 8; i++) begin
            std_read(v);
            check("R5 slow read order", v, 500 + i);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_standard();
        t_fill();
        rhalf = 3;
        t_lookahead();
        t_slow_read();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule